// File: doc/BRIEF.md
# Key-Protected Controller Register File

This block is the software-visible register bank of a DRAM controller. It sits behind a plain memory-mapped port with a 4 KB window of 32-bit words. The port has one byte address shared by reads and writes, a write strobe, a read strobe and a registered read-data output. Only whole-word accesses exist, so the two lowest address bits are ignored. No DRAM commands, PHY training, ECC or scrambling take place here. The bank only reproduces what software sees when it programs and polls the controller.

Writes are gated by a protection word at offset 0x00. Writing a magic value opens the bank. A second magic value seals it until the next reset. Any other value shuts it again. A few test and fault-injection words stay writable whatever the lock state. Several words never store raw data. The configuration word keeps its read-only fields and a size code taken from a parameter. The PHY status word and the ECC test control word get fixed bits forced on every write. A one-cycle `writeBlocked` pulse reports each write that the lock discards.

Top module: `dram_cfg_regbank`

## Requirements
- R1: A write to byte offset 0x00 stores 0x00000001 when the data is 0xFC600309 and 0x00000010 when the data is 0xDEADDEAD. Any other data stores 0x00000000. Reading offset 0x00 returns the stored value.
- R2: While offset 0x00 reads 0x10 (sealed), every write to a protected word is discarded, including writes to offset 0x00. Each such write is followed by a one-cycle `writeBlocked` pulse. Only reset leaves the sealed state.
- R3: While offset 0x00 reads 0x00 (shut), writes to protected words other than offset 0x00 are discarded with a `writeBlocked` pulse. Offset 0x00 itself stays writable, so the bank can be reopened.
- R4: Offsets 0x74, 0x7C and 0xB4 are unprotected. They store the written data in every lock state and never raise `writeBlocked`.
- R5: While offset 0x00 reads 0x01 (open), a write to a protected word with no special rule (for example 0x08 or 0x6C) stores the data unchanged. No `writeBlocked` pulse follows.
- R6: The configuration word at 0x04 reads bits 31:28 as 3, bits 18:14 as 0, bit 6 as 0 and bits 3:2 as 3 whatever is written to it. Bits 27:19, 13:7 and 5:4 store the written data.
- R7: Configuration bits 1:0 always hold the size code of parameter SIZE_MB: 256 gives 0, 512 gives 1, 1024 gives 2 and 2048 gives 3. With the default of 512, the word reads 0x3000000D after reset.
- R8: An accepted write to offset 0x60 stores the data with bit 0 cleared and bit 4 set.
- R9: An accepted write to offset 0x70 stores the data with bit 12 set and bit 13 cleared.
- R10: After reset, every word reads 0 except the following:
  - 0x04 holds its fixed value.
  - 0x400 reads 0x2.
  - 0x468 and 0x47C read 0xFF.
  - 0x450 reads 0x0FFFFFFF.

  Because 0x00 reads 0, the bank starts shut. `rdata` and `writeBlocked` are 0 after reset.
- R11: Words at byte offset 0x500 and above lie outside the bank. A read there returns 0. A write there changes nothing and never raises `writeBlocked`.
- R12: `rdata` changes only in the cycle after `re` is high, and it then shows the word stored before that edge. Address bits 1:0 do not affect which word is accessed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Byte address within the 4 KB window |
| wdata | input | 32 | Write data |
| we | input | 1 | Write strobe, one word per cycle |
| re | input | 1 | Read strobe |
| rdata | output | 32 | Read data, registered |
| writeBlocked | output | 1 | One-cycle pulse after a write discarded by the lock |

## Verification
Directed sequences walk the lock through shut, open, shut again and sealed. In each state the bench writes to a plain protected word, a free word and the protection word itself. This separates "discarded with pulse" from "stored" for every combination of lock state and word class. All-ones and all-zeros writes to the configuration, PHY status and ECC test words show which bits are forced and which bits store the data. Reads at the reset-default addresses, at offset 0x500 and beyond, and with nonzero low address bits test the reset image, the out-of-range decode and the word alignment. A seeded random run then mixes key values, arbitrary data and reads over all special offsets and random offsets. It also resets the bank periodically, so that a hidden dependence between lock history and the forced-field rules would show up as a mismatch against the bench model.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

  localparam int WORD_W = 32;

  // lock keys and the codes stored for them
  localparam logic [WORD_W-1:0] KEY_OPEN  = 32'hFC60_0309;
  localparam logic [WORD_W-1:0] KEY_SEAL  = 32'hDEAD_DEAD;
  localparam logic [WORD_W-1:0] LOCK_OPEN = 32'h0000_0001;
  localparam logic [WORD_W-1:0] LOCK_SEAL = 32'h0000_0010;
  localparam logic [WORD_W-1:0] LOCK_SHUT = 32'h0000_0000;

  // word indices whose behaviour differs from plain storage
  localparam int IDX_LOCK    = 0;
  localparam int IDX_CONF    = 1;
  localparam int IDX_PHYSTAT = 24;
  localparam int IDX_ECCTEST = 28;
  localparam int IDX_FREE_A  = 29;
  localparam int IDX_FREE_B  = 31;
  localparam int IDX_FREE_C  = 45;

  // configuration word fields
  localparam logic [WORD_W-1:0] CONF_RW_MASK  = 32'h0FF8_3FB0;
  localparam logic [WORD_W-1:0] CONF_FIXED    = 32'h3000_000C;
  localparam logic [WORD_W-1:0] PHY_BUSY_BIT  = 32'h0000_0001;
  localparam logic [WORD_W-1:0] PHY_LOCK_BIT  = 32'h0000_0010;
  localparam logic [WORD_W-1:0] ECC_DONE_BIT  = 32'h0000_1000;
  localparam logic [WORD_W-1:0] ECC_FAIL_BIT  = 32'h0000_2000;

  // PHY status area offsets relative to its base word
  localparam int PHY_OFS_EYE_A = 26;
  localparam int PHY_OFS_EYE_B = 31;
  localparam int PHY_OFS_PASS  = 20;

  typedef enum logic [2:0] {
    K_PLAIN,
    K_LOCK,
    K_CONF,
    K_PHYSTAT,
    K_ECCTEST,
    K_FREE
  } wkind_e;

  typedef struct packed {
    logic   commit;
    logic   drop;
    wkind_e kind;
  } wrStrobe_t;

  function automatic logic [1:0] sizeCode(input int sizeMb);
    case (sizeMb)
      256:     return 2'd0;
      512:     return 2'd1;
      1024:    return 2'd2;
      2048:    return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/dcr_ctrl.sv
module dcr_ctrl
  import dcr_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_WORDS = 320,
  localparam int IDX_W    = ADDR_W - 2,
  localparam int SLOT_W   = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic              re,
  input  logic [WORD_W-1:0] lockWord,
  output wrStrobe_t         strb,
  output logic [SLOT_W-1:0] slot,
  output logic              rdHit,
  output logic              rdMiss,
  output logic              writeBlocked
);

  logic [IDX_W-1:0] idx;
  logic             inRange;
  wkind_e           kind;
  logic             isSealed;
  logic             isOpen;
  logic             allow;
  logic             unusedLow;

  assign idx       = addr[ADDR_W-1:2];
  assign unusedLow = ^addr[1:0];
  assign inRange   = int'(idx) < NUM_WORDS;
  assign slot      = idx[SLOT_W-1:0];

  always_comb begin
    if (int'(idx) == IDX_LOCK)                       kind = K_LOCK;
    else if (int'(idx) == IDX_CONF)                  kind = K_CONF;
    else if (int'(idx) == IDX_PHYSTAT)               kind = K_PHYSTAT;
    else if (int'(idx) == IDX_ECCTEST)               kind = K_ECCTEST;
    else if (int'(idx) == IDX_FREE_A ||
             int'(idx) == IDX_FREE_B ||
             int'(idx) == IDX_FREE_C)                kind = K_FREE;
    else                                             kind = K_PLAIN;
  end

  assign isSealed = (lockWord == LOCK_SEAL);
  assign isOpen   = (lockWord == LOCK_OPEN);

  // free words always pass; a seal stops everything else; when shut
  // only the lock word itself may be rewritten
  always_comb begin
    if (kind == K_FREE)      allow = 1'b1;
    else if (isSealed)       allow = 1'b0;
    else if (kind == K_LOCK) allow = 1'b1;
    else                     allow = isOpen;
  end

  assign strb.commit = we & inRange & allow;
  assign strb.drop   = we & inRange & ~allow;
  assign strb.kind   = kind;

  assign rdHit  = re & inRange;
  assign rdMiss = re & ~inRange;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) writeBlocked <= 1'b0;
    else       writeBlocked <= strb.drop;
  end

endmodule

// File: rtl/dcr_datapath.sv
module dcr_datapath
  import dcr_pkg::*;
#(
  parameter int NUM_WORDS = 320,
  parameter int SIZE_MB   = 512,
  parameter int PHY_BASE  = 256,
  localparam int SLOT_W   = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         strb,
  input  logic [SLOT_W-1:0] slot,
  input  logic [WORD_W-1:0] wdata,
  input  logic              rdHit,
  input  logic              rdMiss,
  output logic [WORD_W-1:0] rdata,
  output logic [WORD_W-1:0] lockWord
);

  localparam logic [WORD_W-1:0] CONF_RESET =
    CONF_FIXED | {{(WORD_W-2){1'b0}}, sizeCode(SIZE_MB)};

  logic [WORD_W-1:0] bank [NUM_WORDS];
  logic [WORD_W-1:0] stored;
  logic              unusedDrop;

  assign unusedDrop = strb.drop;

  function automatic logic [WORD_W-1:0] resetVal(input int w);
    if (w == IDX_CONF)                  return CONF_RESET;
    else if (w == PHY_BASE)             return 32'h0000_0002;
    else if (w == PHY_BASE + PHY_OFS_EYE_A) return 32'h0000_00FF;
    else if (w == PHY_BASE + PHY_OFS_EYE_B) return 32'h0000_00FF;
    else if (w == PHY_BASE + PHY_OFS_PASS)  return 32'h0FFF_FFFF;
    else                                return '0;
  endfunction

  // per-word write rules
  always_comb begin
    case (strb.kind)
      K_LOCK: begin
        if (wdata == KEY_OPEN)      stored = LOCK_OPEN;
        else if (wdata == KEY_SEAL) stored = LOCK_SEAL;
        else                        stored = LOCK_SHUT;
      end
      K_CONF:    stored = (wdata & CONF_RW_MASK) | CONF_RESET;
      K_PHYSTAT: stored = (wdata & ~PHY_BUSY_BIT) | PHY_LOCK_BIT;
      K_ECCTEST: stored = (wdata | ECC_DONE_BIT) & ~ECC_FAIL_BIT;
      default:   stored = wdata;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < NUM_WORDS; w++) bank[w] <= resetVal(w);
    end else if (strb.commit) begin
      bank[slot] <= stored;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       rdata <= '0;
    else if (rdHit)  rdata <= bank[slot];
    else if (rdMiss) rdata <= '0;
  end

  assign lockWord = bank[IDX_LOCK];

endmodule

// File: rtl/dram_cfg_regbank.sv
module dram_cfg_regbank
  import dcr_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_WORDS = 320,
  parameter int SIZE_MB   = 512,
  parameter int PHY_BASE  = 256,
  localparam int SLOT_W   = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              we,
  input  logic              re,
  output logic [31:0]       rdata,
  output logic              writeBlocked
);

  wrStrobe_t         strb;
  logic [SLOT_W-1:0] slot;
  logic              rdHit;
  logic              rdMiss;
  logic [31:0]       protWord;

  dcr_ctrl #(
    .ADDR_W    (ADDR_W),
    .NUM_WORDS (NUM_WORDS)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .addr         (addr),
    .we           (we),
    .re           (re),
    .lockWord     (protWord),
    .strb         (strb),
    .slot         (slot),
    .rdHit        (rdHit),
    .rdMiss       (rdMiss),
    .writeBlocked (writeBlocked)
  );

  dcr_datapath #(
    .NUM_WORDS (NUM_WORDS),
    .SIZE_MB   (SIZE_MB),
    .PHY_BASE  (PHY_BASE)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .slot     (slot),
    .wdata    (wdata),
    .rdHit    (rdHit),
    .rdMiss   (rdMiss),
    .rdata    (rdata),
    .lockWord (protWord)
  );

endmodule

// File: rtl/dcr_checker.sv
module dcr_checker #(
  parameter int ADDR_W    = 12,
  parameter int NUM_WORDS = 320
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              we,
  input logic              re,
  input logic [31:0]       rdata,
  input logic              writeBlocked,
  input logic [31:0]       protWord
);

  logic [ADDR_W-3:0] wIdx;
  logic              inBank;
  logic              freeWord;

  assign wIdx     = addr[ADDR_W-1:2];
  assign inBank   = int'(wIdx) < NUM_WORDS;
  assign freeWord = int'(wIdx) == 29 || int'(wIdx) == 31 || int'(wIdx) == 45;

  p_lock_code_r1: assert property (@(posedge clk) disable iff (!rstN)
    protWord == 32'h0 || protWord == 32'h1 || protWord == 32'h10);

  p_seal_sticky_r2: assert property (@(posedge clk) disable iff (!rstN)
    protWord == 32'h10 |=> protWord == 32'h10);

  p_seal_blocks_r2: assert property (@(posedge clk) disable iff (!rstN)
    (we && inBank && !freeWord && protWord == 32'h10) |=> writeBlocked);

  p_pulse_cause_r2: assert property (@(posedge clk) disable iff (!rstN)
    writeBlocked |-> $past(we));

  p_shut_drops_r3: assert property (@(posedge clk) disable iff (!rstN)
    (we && inBank && !freeWord && wIdx != '0 && protWord == 32'h0) |=> writeBlocked);

  p_free_pass_r4: assert property (@(posedge clk) disable iff (!rstN)
    (we && freeWord) |=> !writeBlocked);

  p_outside_read_r11: assert property (@(posedge clk) disable iff (!rstN)
    (re && !inBank) |=> rdata == 32'h0);

  p_outside_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    (we && !inBank) |=> !writeBlocked);

  p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    !re |=> $stable(rdata));

endmodule

bind dram_cfg_regbank dcr_checker #(
  .ADDR_W    (ADDR_W),
  .NUM_WORDS (NUM_WORDS)
) u_chk (.*);

// File: tb/dram_cfg_regbank_bench.sv
`timescale 1ns/1ps
module dram_cfg_regbank_bench;

  localparam int NW = 320;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic        re = 1'b0;
  logic [31:0] rdata;
  logic        writeBlocked;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [NW];

  always #2 clk = ~clk;

  dram_cfg_regbank u_dram_cfg_regbank (
    .clk(clk), .rstN(rstN), .addr(addr), .wdata(wdata),
    .we(we), .re(re), .rdata(rdata), .writeBlocked(writeBlocked)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit isFree(input int i);
    return i == 29 || i == 31 || i == 45;
  endfunction

  function automatic logic [31:0] shape(input int i, input logic [31:0] d);
    case (i)
      0:  return (d == 32'hFC600309) ? 32'h1 : (d == 32'hDEADDEAD) ? 32'h10 : 32'h0;
      1:  return (d & 32'h0FF83FB0) | 32'h3000000D;
      24: return (d & ~32'h1) | 32'h10;
      28: return (d | 32'h1000) & ~32'h2000;
      default: return d;
    endcase
  endfunction

  function automatic void modelReset();
    for (int i = 0; i < NW; i++) model[i] = 32'h0;
    model[1]   = 32'h3000000D;
    model[256] = 32'h2;
    model[282] = 32'hFF;
    model[287] = 32'hFF;
    model[276] = 32'h0FFFFFFF;
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; we = 1'b0; re = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    modelReset();
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string req);
    int  i = int'(a[11:2]);
    bit  ok;
    bit  expBlk = 1'b0;
    if (i < NW) begin
      if (isFree(i))                   ok = 1'b1;
      else if (model[0] == 32'h10)     ok = 1'b0;
      else if (i == 0)                 ok = 1'b1;
      else                             ok = (model[0] == 32'h1);
      expBlk = !ok;
      if (ok) model[i] = shape(i, d);
    end
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk); #1;
    chk({req, " writeBlocked"}, {31'b0, writeBlocked}, {31'b0, expBlk});
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input string req);
    int i = int'(a[11:2]);
    logic [31:0] e = (i < NW) ? model[i] : 32'h0;
    @(negedge clk);
    addr = a; re = 1'b1;
    @(posedge clk); #1;
    chk({req, " rdata"}, rdata, e);
    @(negedge clk);
    re = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] held;
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R10 reset rdata", rdata, 32'h0);
    chk("R10 reset writeBlocked", {31'b0, writeBlocked}, 32'h0);
    rd(12'h000, "R10 lock word");
    rd(12'h004, "R7 size code");
    rd(12'h400, "R10 phy status");
    rd(12'h468, "R10 eye A");
    rd(12'h47C, "R10 eye B");
    rd(12'h450, "R10 pass word");
    rd(12'h404, "R10 zero word");
    // shut after reset
    wr(12'h008, 32'hAAAA5555, "R3 shut drop");
    rd(12'h008, "R3 shut drop");
    wr(12'h074, 32'h11112222, "R4 free shut");
    rd(12'h074, "R4 free shut");
    // open
    wr(12'h000, 32'hFC600309, "R1 open key");
    rd(12'h000, "R1 open key");
    wr(12'h008, 32'h12345678, "R5 plain store");
    rd(12'h008, "R5 plain store");
    wr(12'h06C, 32'hCAFEF00D, "R5 plain 6c");
    rd(12'h06C, "R5 plain 6c");
    wr(12'h004, 32'hFFFFFFFF, "R6 conf ones");
    rd(12'h004, "R6 conf ones");
    wr(12'h004, 32'h00000000, "R6 conf zeros");
    rd(12'h004, "R7 conf zeros");
    wr(12'h060, 32'h00000001, "R8 phy busy");
    rd(12'h060, "R8 phy busy");
    wr(12'h060, 32'hFFFFFFFF, "R8 phy ones");
    rd(12'h060, "R8 phy ones");
    wr(12'h070, 32'h00002000, "R9 ecc fail");
    rd(12'h070, "R9 ecc fail");
    // shut again and reopen
    wr(12'h000, 32'h00012345, "R1 other key");
    rd(12'h000, "R1 other key");
    wr(12'h070, 32'h0, "R3 shut ecc");
    rd(12'h070, "R3 shut ecc");
    wr(12'h000, 32'hFC600309, "R3 reopen");
    rd(12'h000, "R3 reopen");
    // seal
    wr(12'h000, 32'hDEADDEAD, "R1 seal key");
    rd(12'h000, "R1 seal key");
    wr(12'h000, 32'hFC600309, "R2 sealed lock");
    rd(12'h000, "R2 sealed lock");
    wr(12'h004, 32'h0FF80000, "R2 sealed conf");
    rd(12'h004, "R2 sealed conf");
    wr(12'h0B4, 32'h5A5A5A5A, "R4 free sealed");
    rd(12'h0B4, "R4 free sealed");
    wr(12'h07C, 32'h01020304, "R4 free B");
    rd(12'h07C, "R4 free B");
    // outside the bank, alignment, hold
    rd(12'h500, "R11 read 500");
    rd(12'hFFC, "R11 read ffc");
    wr(12'h600, 32'hFFFFFFFF, "R11 write 600");
    rd(12'h600, "R11 write 600");
    rd(12'h402, "R12 low bits");
    held = rdata;
    @(negedge clk); addr = 12'h468;
    repeat (3) @(negedge clk);
    chk("R12 hold", rdata, held);
    // reset clears seal
    doReset();
    rd(12'h000, "R2 reset unseal");
    rd(12'h0B4, "R10 free cleared");
    // seeded random mix
    void'($urandom(32'd20240611));
    for (int n = 0; n < 1500; n++) begin
      int pick = $urandom_range(0, 12);
      logic [11:0] a;
      logic [31:0] d = $urandom();
      case (pick)
        0: begin
          a = 12'h000;
          case ($urandom_range(0, 7))
            0, 1, 2: d = 32'hFC600309;
            3:       d = 32'hDEADDEAD;
            default: ;
          endcase
        end
        1: a = 12'h004;
        2: a = 12'h008;
        3: a = 12'h060;
        4: a = 12'h06C;
        5: a = 12'h070;
        6: a = 12'h074;
        7: a = 12'h07C;
        8: a = 12'h0B4;
        9: a = 12'h468;
        10: a = 12'h500 + 12'($urandom_range(0, 700)) * 4;
        default: a = 12'($urandom_range(0, NW - 1)) * 4 + 12'($urandom_range(0, 3));
      endcase
      if ($urandom_range(0, 1) == 0) wr(a, d, "R5 random write");
      else                           rd(a, "R12 random read");
      if (n % 250 == 249) doReset();
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule